// File: doc/BRIEF.md
# Operand Effective-Address Sequencer

This block resolves the effective address of one instruction for a 64-bit accumulator processor. The decoder hands it an addressing-mode class, the prefix byte, the program counter and the two index registers, and pulses a start input. The block then pulls operand bytes one at a time through a byte-wide request/valid read port and assembles them little-endian. It adds an index where the mode calls for one and, for the three indirect modes, reads an 8-byte pointer. It returns the final address and the advanced program counter with a one-cycle done strobe.

How many operand bytes follow the opcode is chosen per instruction by two prefix bits. Page-relative modes and absolute mode decode those bits through different length tables. Immediate mode reads nothing: the operand sits at the PC, and the PC skips a power-of-two span chosen by the upper prefix nibble. A short-step input, driven by the decoder for stack, shift and rotate style opcodes, forces that step to one byte.

Top module: `opaddr_gen`

## Requirements
- R1: In page modes (mode_i codes 2 page, 3 page+X, 4 page+Y, 5 indirect, 6 indirect-X, 7 indirect-Y) prefix_i[3:2] sets the operand length: code 0 is 1 byte, 1 is 3 bytes, 2 is 6 bytes and 3 is 4 bytes. pc_o is pc_i plus that length, modulo 2^64.
- R2: In absolute mode (mode_i code 8) prefix_i[3:2] sets the operand length: code 0 is 2 bytes, 1 is 5 bytes, 2 is 7 bytes and 3 is 8 bytes. pc_o is pc_i plus that length.
- R3: Operand bytes are read from pc_i, pc_i+1 and onward, wrapping modulo 2^64. The byte at pc_i+k lands in address bits [8k+7:8k], and bits above the last byte read are zero. In mode 2 and mode 8, ea_o is this operand.
- R4: In immediate mode (mode_i code 1) ea_o equals pc_i and no memory read occurs. pc_o is pc_i + (1 << prefix_i[7:4]), or pc_i + 1 when short_step_i is 1. done_o rises one cycle after start.
- R5: In mode 3 ea_o is the operand plus x_i, and in mode 4 it is the operand plus y_i, both modulo 2^64.
- R6: In mode 5 eight bytes are read little-endian starting at the operand address, and the result is ea_o.
- R7: In mode 6 the eight-byte pointer is read starting at operand + x_i, and ea_o is that pointer with nothing added.
- R8: In mode 7 the pointer is read starting at the operand, and ea_o is the pointer + y_i.
- R9: Implied mode (mode_i code 0, and the unused codes 9 to 15) performs no memory read. pc_o equals pc_i and ea_o is zero. done_o rises one cycle after start.
- R10: At most one byte is transferred per clock. While mem_req_o is high and mem_valid_i is low, mem_addr_o holds steady. The number of transfers per instruction is the operand length, plus 8 in the indirect modes.
- R11: done_o is high for exactly one cycle per instruction. ea_o and pc_o hold their values until the next accepted start. start_i is ignored while busy_o is high. After reset done_o, busy_o and mem_req_o are low and ea_o and pc_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an address computation (taken when idle) |
| mode_i | input | 4 | Addressing-mode class code |
| prefix_i | input | 8 | Instruction prefix byte |
| short_step_i | input | 1 | Immediate mode steps the PC by one byte |
| pc_i | input | AW | Program counter at the first operand byte |
| x_i | input | AW | X index register |
| y_i | input | AW | Y index register |
| mem_req_o | output | 1 | Byte read request |
| mem_addr_o | output | AW | Byte read address |
| mem_valid_i | input | 1 | Read data valid this cycle |
| mem_data_i | input | 8 | Read data byte |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | Result valid strobe |
| ea_o | output | AW | Effective address |
| pc_o | output | AW | Advanced program counter |

## Verification
The bench builds the block with its default 64-bit address width, so every 8-byte pointer and every wrap at the top of the address space is the full-size case. It sweeps every mode against all four prefix length codes, with three combinations of PC, X and Y. One of those combinations sits just below 2^64, so operand reads, index additions and pointer reads all wrap. Immediate mode is swept over all sixteen step exponents with and without short step. Alternate runs stall the valid input every third cycle, which exercises the held-address rule and the transfer count.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;
  typedef enum logic [3:0] {
    AM_IMPL = 4'd0,
    AM_IMM  = 4'd1,
    AM_PG   = 4'd2,
    AM_PGX  = 4'd3,
    AM_PGY  = 4'd4,
    AM_IND  = 4'd5,
    AM_INDX = 4'd6,
    AM_INDY = 4'd7,
    AM_ABS  = 4'd8
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RESOLVE,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/opaddr_len.sv
module opaddr_len
  import opaddr_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic [3:0]    mode_i,
  input  logic [1:0]    code_i,
  output logic [CW-1:0] len_o,
  output logic          fetch_o
);
  always_comb begin
    len_o   = '0;
    fetch_o = 1'b0;
    unique case (mode_i)
      AM_PG, AM_PGX, AM_PGY, AM_IND, AM_INDX, AM_INDY: begin
        fetch_o = 1'b1;
        unique case (code_i)
          2'd0: len_o = CW'(1);
          2'd1: len_o = CW'(3);
          2'd2: len_o = CW'(6);
          default: len_o = CW'(4);
        endcase
      end
      AM_ABS: begin
        fetch_o = 1'b1;
        unique case (code_i)
          2'd0: len_o = CW'(2);
          2'd1: len_o = CW'(5);
          2'd2: len_o = CW'(7);
          default: len_o = CW'(8);
        endcase
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/opaddr_bytes.sv
module opaddr_bytes #(
  parameter int NB = 8,
  parameter int IW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            we_i,
  input  logic [IW-1:0]   lane_i,
  input  logic [7:0]      byte_i,
  output logic [NB*8-1:0] word_o
);
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              lane_q <= '0;
      else if (clr_i)                           lane_q <= '0;
      else if (we_i && (lane_i == IW'(g)))      lane_q <= byte_i;
    end
    assign word_o[g*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/opaddr_gen.sv
module opaddr_gen
  import opaddr_pkg::*;
#(
  parameter int AW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    mode_i,
  input  logic [7:0]    prefix_i,
  input  logic          short_step_i,
  input  logic [AW-1:0] pc_i,
  input  logic [AW-1:0] x_i,
  input  logic [AW-1:0] y_i,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [7:0]    mem_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] ea_o,
  output logic [AW-1:0] pc_o
);
  localparam int NB = AW / 8;
  localparam int IW = (NB > 1) ? $clog2(NB) : 1;
  localparam int CW = $clog2(NB + 1);

  seq_st_e         st_q;
  amode_e          mode_q;
  logic            ptr_q;
  logic [AW-1:0]   base_q, x_q, y_q, ea_q, pcn_q;
  logic [IW-1:0]   idx_q, last_q;
  logic [CW-1:0]   len_w;
  logic            fetch_w;
  logic            coll_clr, coll_we;
  logic [AW-1:0]   word_w;
  logic            unused_pfx;

  assign unused_pfx = ^prefix_i[1:0];

  opaddr_len #(.CW(CW)) u_len (
    .mode_i  (mode_i),
    .code_i  (prefix_i[3:2]),
    .len_o   (len_w),
    .fetch_o (fetch_w)
  );

  assign coll_we  = (st_q == ST_FETCH) && mem_valid_i;
  assign coll_clr = ((st_q == ST_IDLE) && start_i) || ((st_q == ST_RESOLVE) && !ptr_q);

  opaddr_bytes #(.NB(NB), .IW(IW)) u_bytes (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (coll_clr),
    .we_i   (coll_we),
    .lane_i (idx_q),
    .byte_i (mem_data_i),
    .word_o (word_w)
  );

  assign mem_req_o  = (st_q == ST_FETCH);
  assign mem_addr_o = base_q + AW'(idx_q);
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_DONE);
  assign ea_o       = ea_q;
  assign pc_o       = pcn_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      mode_q <= AM_IMPL;
      ptr_q  <= 1'b0;
      base_q <= '0;
      x_q    <= '0;
      y_q    <= '0;
      ea_q   <= '0;
      pcn_q  <= '0;
      idx_q  <= '0;
      last_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          mode_q <= amode_e'(mode_i);
          x_q    <= x_i;
          y_q    <= y_i;
          ptr_q  <= 1'b0;
          idx_q  <= '0;
          base_q <= pc_i;
          if (fetch_w) begin
            last_q <= IW'(len_w - CW'(1));
            pcn_q  <= pc_i + AW'(len_w);
            st_q   <= ST_FETCH;
          end else if (mode_i == AM_IMM) begin
            ea_q  <= pc_i;
            pcn_q <= pc_i + (short_step_i ? AW'(1) : (AW'(1) << prefix_i[7:4]));
            st_q  <= ST_DONE;
          end else begin
            ea_q  <= '0;
            pcn_q <= pc_i;
            st_q  <= ST_DONE;
          end
        end
        ST_FETCH: if (mem_valid_i) begin
          if (idx_q == last_q) st_q  <= ST_RESOLVE;
          else                 idx_q <= idx_q + IW'(1);
        end
        ST_RESOLVE: begin
          if (ptr_q) begin
            ea_q <= word_w + ((mode_q == AM_INDY) ? y_q : '0);
            st_q <= ST_DONE;
          end else begin
            unique case (mode_q)
              AM_PGX: begin ea_q <= word_w + x_q; st_q <= ST_DONE; end
              AM_PGY: begin ea_q <= word_w + y_q; st_q <= ST_DONE; end
              AM_IND, AM_INDX, AM_INDY: begin
                // index before the pointer read only for indirect-X
                base_q <= word_w + ((mode_q == AM_INDX) ? x_q : '0);
                ptr_q  <= 1'b1;
                idx_q  <= '0;
                last_q <= IW'(NB - 1);
                st_q   <= ST_FETCH;
              end
              default: begin ea_q <= word_w; st_q <= ST_DONE; end
            endcase
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/opaddr_gen_chk.sv
module opaddr_gen_chk #(
  parameter int AW = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [3:0]    mode_i,
  input logic [AW-1:0] pc_i,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_valid_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [AW-1:0] ea_o,
  input logic [AW-1:0] pc_o
);
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_hold_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(ea_o) && $stable(pc_o)));

  a_r10_hold_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  a_r10_next_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_valid_i) |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) + AW'(1)));

  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  a_r9_implied: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && mode_i == 4'd0) |=> (done_o && !mem_req_o && pc_o == $past(pc_i) && ea_o == '0));

  a_r4_immediate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && mode_i == 4'd1) |=> (done_o && ea_o == $past(pc_i)));
endmodule

bind opaddr_gen opaddr_gen_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mode_i      (mode_i),
  .pc_i        (pc_i),
  .mem_req_o   (mem_req_o),
  .mem_addr_o  (mem_addr_o),
  .mem_valid_i (mem_valid_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .ea_o        (ea_o),
  .pc_o        (pc_o)
);

// File: tb/opaddr_gen_test.sv
module opaddr_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [7:0]  pfx = '0;
  logic        shrt = 1'b0;
  logic [63:0] pc = '0, xr = '0, yr = '0;
  logic        mem_req, mem_valid, busy, done;
  logic [63:0] mem_addr, ea, pcn;
  logic [7:0]  mem_data;
  int          total = 0, bad = 0;
  int          stall_cnt = 0, rd_cnt = 0;
  bit          stall_en = 1'b0;

  always #5 clk = ~clk;

  function automatic logic [7:0] mbyte(input logic [63:0] a);
    return (a[7:0] * 8'd29 + a[15:8] + a[63:56]) ^ 8'hC3;
  endfunction

  function automatic logic [63:0] le_read(input logic [63:0] a, input int n);
    logic [63:0] v = '0;
    for (int i = 0; i < n; i++) v[i*8 +: 8] = mbyte(a + 64'(i));
    return v;
  endfunction

  assign mem_data  = mbyte(mem_addr);
  assign mem_valid = mem_req && (!stall_en || (stall_cnt % 3 != 0));

  always @(negedge clk) stall_cnt <= stall_cnt + 1;
  always @(posedge clk) if (mem_req && mem_valid) rd_cnt <= rd_cnt + 1;

  opaddr_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .prefix_i(pfx),
    .short_step_i(shrt), .pc_i(pc), .x_i(xr), .y_i(yr),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_valid_i(mem_valid), .mem_data_i(mem_data),
    .busy_o(busy), .done_o(done), .ea_o(ea), .pc_o(pcn)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run(input int m, input logic [7:0] p, input bit s,
                     input logic [63:0] pcv, input logic [63:0] xv, input logic [63:0] yv,
                     input bit poke);
    int n = 0, lat = 0, rd0;
    logic [63:0] op, ea_e, pc_e;
    string tag;
    if (m >= 2 && m <= 7) n = (p[3:2] == 0) ? 1 : (p[3:2] == 1) ? 3 : (p[3:2] == 2) ? 6 : 4;
    if (m == 8)           n = (p[3:2] == 0) ? 2 : (p[3:2] == 1) ? 5 : (p[3:2] == 2) ? 7 : 8;
    op = le_read(pcv, n);
    pc_e = pcv + 64'(n);
    case (m)
      1: begin ea_e = pcv; pc_e = pcv + (s ? 64'd1 : (64'd1 << p[7:4])); tag = "R4"; end
      2: begin ea_e = op; tag = "R1 R3"; end
      3: begin ea_e = op + xv; tag = "R5 x"; end
      4: begin ea_e = op + yv; tag = "R5 y"; end
      5: begin ea_e = le_read(op, 8); tag = "R6"; end
      6: begin ea_e = le_read(op + xv, 8); tag = "R7"; end
      7: begin ea_e = le_read(op, 8) + yv; tag = "R8"; end
      8: begin ea_e = op; tag = "R2 R3"; end
      default: begin ea_e = '0; pc_e = pcv; tag = "R9"; end
    endcase
    @(negedge clk);
    rd0 = rd_cnt;
    mode = 4'(m); pfx = p; shrt = s; pc = pcv; xr = xv; yr = yv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    if (poke && busy) begin
      mode = 4'd0; pc = ~pcv; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL %s watchdog got=no_done exp=done", tag);
      return;
    end
    chk({tag, " ea"}, ea, ea_e);
    chk({tag, " pc"}, pcn, pc_e);
    chk("R10 reads", 64'(rd_cnt - rd0), 64'(n + ((m >= 5 && m <= 7) ? 8 : 0)));
    if (m <= 1 || m > 8) chk({tag, " latency"}, 64'(lat), 64'd1);
    @(negedge clk);
    chk("R11 done one cycle", {63'd0, done}, 64'd0);
    if (poke) begin
      chk("R11 start ignored ea", ea, ea_e);
      chk("R11 start ignored pc", pcn, pc_e);
    end
  endtask

  initial begin
    #1_500_000;
    total++; bad++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] pcs [3];
    logic [63:0] xs  [3];
    logic [63:0] ys  [3];
    pcs[0] = 64'h0000_0000_0000_1000; xs[0] = 64'd5;                  ys[0] = 64'd9;
    pcs[1] = 64'hFFFF_FFFF_FFFF_FFFD; xs[1] = 64'hFFFF_FFFF_FFFF_FFFF; ys[1] = 64'h8000_0000_0000_0001;
    pcs[2] = 64'h0123_4567_89AB_CDEF; xs[2] = 64'h0000_1234_0000_0000; ys[2] = 64'd0;
    repeat (3) @(negedge clk);
    chk("R11 reset done",  {63'd0, done}, 64'd0);
    chk("R11 reset busy",  {63'd0, busy}, 64'd0);
    chk("R11 reset req",   {63'd0, mem_req}, 64'd0);
    chk("R11 reset ea",    ea, 64'd0);
    chk("R11 reset pc",    pcn, 64'd0);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      stall_en = (k == 1);
      for (int m = 2; m <= 8; m++)
        for (int c = 0; c < 4; c++)
          run(m, 8'(c << 2) | 8'h51, 1'b0, pcs[k], xs[k], ys[k], 1'b0);
      run(0, 8'hFF, 1'b0, pcs[k], xs[k], ys[k], 1'b0);
      run(12, 8'h0C, 1'b0, pcs[k], xs[k], ys[k], 1'b0);
    end
    for (int e = 0; e < 16; e++) begin
      run(1, 8'(e << 4) | 8'h0C, 1'b0, pcs[e % 3], 64'd0, 64'd0, 1'b0);
      run(1, 8'(e << 4), 1'b1, pcs[e % 3], 64'd0, 64'd0, 1'b0);
    end
    stall_en = 1'b1;
    run(7, 8'h0C, 1'b0, pcs[2], xs[0], ys[1], 1'b1);
    run(8, 8'h08, 1'b0, pcs[1], xs[0], ys[0], 1'b1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule